// File: doc/BRIEF.md
# TDM Timeslot Enable Strobe Generator

This block follows a frame-synchronised time-division multiplexed serial stream that carries two bearer channels (B1, B2) and one signalling channel (D). It counts bit times from the receive frame sync. From that count it drives an active-low slot-enable strobe that is low during the bit times of every channel in the enabled set. The strobe is the OR of those channels' windows, so a downstream serial controller can take the enabled channels as one merged stream instead of routing each one on its own.

The block also produces a conditioned window. The window goes high on the frame sync and falls once the enabled run of slots ends, which gives the downstream controller a clean frame-aligned gate. The window is only meaningful when the enabled slots form one unbroken run that starts at bit 0. A layout check therefore flags any active configuration that leaves a gap, overlaps, or starts later than bit 0.

The start position of each channel is programmable. B1 and B2 share a single enable. The configuration is taken into use only at frame boundaries.

Top module: `tdm_slot_strobe`

## Requirements
- R1: After reset, and until the first frame sync is sampled, `slot_en_n` is 1, `win` is 0 and `cfg_err` is 0, whatever the configuration inputs hold.
- R2: On a rising `clk` edge where `fsync` is 1, the bit position becomes 0. Each later edge advances it by one. After position FRAME_LEN-1 (default 31) it wraps to 0 without any frame sync, and the slot pattern repeats in every frame.
- R3: `slot_en_n` is 0 exactly at the positions p that satisfy start <= p < start+length for at least one enabled channel. B1 and B2 are B_LEN (8) bits long and D is D_LEN (2) bits long.
- R4: A single enable `cfg_b_en` includes or excludes B1 and B2 together. With it set and `cfg_d_en` clear, both 8-bit B windows appear in the strobe and the D window does not.
- R5: The positions and enables are captured only on the edge that starts a frame, meaning a sampled frame sync or a wrap. A change made in the middle of a frame has no effect on `slot_en_n` until the next frame starts.
- R6: `win` becomes 1 on every edge where `fsync` is sampled 1. This set takes priority over the clear.
- R7: `win` returns to 0 on the edge that follows the first bit time where `slot_en_n` is high after having been low. It stays 0 until the next frame sync. With no channel enabled, `win` stays 1.
- R8: `cfg_err` is 1 when the active configuration enables at least one channel and the enabled ranges overlap, leave a gap, or do not begin at position 0. It is 0 for an empty set and for any gap-free run that starts at 0, whatever the channel order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; every rising edge is one bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Receive frame sync, sampled on `clk` |
| cfg_b1_pos | input | POS_W | Start position of B1 in the frame |
| cfg_b2_pos | input | POS_W | Start position of B2 in the frame |
| cfg_d_pos | input | POS_W | Start position of D in the frame |
| cfg_b_en | input | 1 | Shared enable for B1 and B2 |
| cfg_d_en | input | 1 | Enable for D |
| slot_en_n | output | 1 | Active-low OR of the enabled slot windows |
| win | output | 1 | Conditioned merge window: set by frame sync, cleared at the end of the run |
| cfg_err | output | 1 | Active configuration is not a gap-free run from position 0 |

## Verification
The bit position, the active configuration and `win` are each one register stage. `slot_en_n` and `cfg_err` are combinational from the position and the active configuration. So after the edge that samples `fsync`, the next sample already shows position 0, the new strobe value, the error flag and `win` high. The fall of `win` appears in the sample for position L+1, where L is the length of the enabled run. The bench drives inputs at the falling edge and samples two time units after each rising edge. It tags every sample with the position it expects at that point, so each result is compared in the bit time where it is due, including across wraps and mid-frame resyncs.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

   localparam int NUM_CH = 3;
   localparam int IDX_B1 = 0;
   localparam int IDX_B2 = 1;
   localparam int IDX_D  = 2;

   // Two half-open intervals [a, a+la) and [b, b+lb) share at least one bit.
   function automatic logic spans_overlap(input int a, input int la,
                                          input int b, input int lb);
      return (a < b + lb) && (b < a + la);
   endfunction

endpackage

// File: rtl/tsg_frame_counter.sv
module tsg_frame_counter #(
   parameter int FRAME_LEN = 32,
   parameter int CNT_W     = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             synced_o,
   output logic             load_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   if (FRAME_LEN < 2) begin : g_bad_len
      $error("tsg_frame_counter: FRAME_LEN must be at least 2");
   end
   if (CNT_W < $clog2(FRAME_LEN)) begin : g_bad_w
      $error("tsg_frame_counter: CNT_W too narrow for FRAME_LEN");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             sync_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sync_q <= 1'b0;
      end else if (fsync_i) begin
         cnt_q  <= '0;
         sync_q <= 1'b1;
      end else if (sync_q) begin
         cnt_q  <= at_last ? '0 : cnt_q + 1'b1;
      end
   end

   assign cnt_o    = cnt_q;
   assign synced_o = sync_q;
   assign load_o   = fsync_i | (sync_q & at_last);

   // R2: a sampled frame sync restarts the frame at position 0
   a_r2_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_i |=> (cnt_q == '0) && sync_q);

   // R2: free running advance and wrap between syncs
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsync_i && sync_q) |=>
         (cnt_q == (($past(cnt_q) == LAST) ? '0 : $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/tsg_slot_decode.sv
module tsg_slot_decode #(
   parameter int CNT_W    = 5,
   parameter int SLOT_LEN = 8
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] pos_i,
   input  logic             en_i,
   output logic             hit_o
);

   if (SLOT_LEN < 1 || SLOT_LEN > (1 << CNT_W)) begin : g_bad_len
      $error("tsg_slot_decode: SLOT_LEN out of range");
   end

   logic [CNT_W:0] c_ext;
   logic [CNT_W:0] lo_ext;
   logic [CNT_W:0] hi_ext;

   assign c_ext  = {1'b0, cnt_i};
   assign lo_ext = {1'b0, pos_i};
   assign hi_ext = lo_ext + (CNT_W+1)'(SLOT_LEN);
   assign hit_o  = en_i & (c_ext >= lo_ext) & (c_ext < hi_ext);

endmodule

// File: rtl/tsg_layout_check.sv
module tsg_layout_check
   import tsg_pkg::*;
#(
   parameter int POS_W = 5,
   parameter int B_LEN = 8,
   parameter int D_LEN = 2
) (
   input  logic [POS_W-1:0]  pos_i [NUM_CH],
   input  logic [NUM_CH-1:0] en_i,
   output logic              err_o
);

   localparam int LEN_OF [NUM_CH] = '{B_LEN, B_LEN, D_LEN};

   int   total;
   int   max_end;
   logic any_en;
   logic from_zero;
   logic clash;

   // No overlap, start at zero and span equal to summed length => gap-free run.
   always_comb begin
      total     = 0;
      max_end   = 0;
      any_en    = 1'b0;
      from_zero = 1'b0;
      clash     = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (en_i[i]) begin
            any_en = 1'b1;
            total  = total + LEN_OF[i];
            if (pos_i[i] == '0) from_zero = 1'b1;
            if (int'(pos_i[i]) + LEN_OF[i] > max_end)
               max_end = int'(pos_i[i]) + LEN_OF[i];
            for (int j = i + 1; j < NUM_CH; j++) begin
               if (en_i[j] && spans_overlap(int'(pos_i[i]), LEN_OF[i],
                                            int'(pos_i[j]), LEN_OF[j]))
                  clash = 1'b1;
            end
         end
      end
      err_o = any_en && (!from_zero || clash || (max_end != total));
   end

endmodule

// File: rtl/tsg_window.sv
module tsg_window (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic raw_en_n_i,
   output logic win_o
);

   logic prev_n_q;
   logic win_q;
   logic run_end;

   assign run_end = raw_en_n_i & ~prev_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n_q <= 1'b1;
         win_q    <= 1'b0;
      end else begin
         prev_n_q <= raw_en_n_i;
         if (set_i)        win_q <= 1'b1;
         else if (run_end) win_q <= 1'b0;
      end
   end

   assign win_o = win_q;

   // R6: frame sync sets the window, with priority
   a_r6_set_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> win_o);

   // R6: the window never rises except through a frame sync
   a_r6_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i |=> !$rose(win_o));

   // R7: end of an enabled run closes the window on the following edge
   a_r7_clear_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && $rose(raw_en_n_i)) |=> !win_o);

endmodule

// File: rtl/tdm_slot_strobe.sv
module tdm_slot_strobe
   import tsg_pkg::*;
#(
   parameter int FRAME_LEN = 32,
   parameter int B_LEN     = 8,
   parameter int D_LEN     = 2,
   parameter int POS_W     = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic [POS_W-1:0] cfg_b1_pos,
   input  logic [POS_W-1:0] cfg_b2_pos,
   input  logic [POS_W-1:0] cfg_d_pos,
   input  logic             cfg_b_en,
   input  logic             cfg_d_en,
   output logic             slot_en_n,
   output logic             win,
   output logic             cfg_err
);

   if (2 * B_LEN + D_LEN > FRAME_LEN) begin : g_bad_fit
      $error("tdm_slot_strobe: channels do not fit in FRAME_LEN");
   end

   logic [POS_W-1:0]  cnt;
   logic              synced;
   logic              load;
   logic [POS_W-1:0]  act_pos [NUM_CH];
   logic              act_b_en;
   logic              act_d_en;
   logic [NUM_CH-1:0] act_en;
   logic [NUM_CH-1:0] hit;

   tsg_frame_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(POS_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync_i  (fsync),
      .cnt_o    (cnt),
      .synced_o (synced),
      .load_o   (load)
   );

   // Active configuration, refreshed only where a frame begins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) act_pos[i] <= '0;
         act_b_en <= 1'b0;
         act_d_en <= 1'b0;
      end else if (load) begin
         act_pos[IDX_B1] <= cfg_b1_pos;
         act_pos[IDX_B2] <= cfg_b2_pos;
         act_pos[IDX_D]  <= cfg_d_pos;
         act_b_en        <= cfg_b_en;
         act_d_en        <= cfg_d_en;
      end
   end

   assign act_en[IDX_B1] = act_b_en;
   assign act_en[IDX_B2] = act_b_en;
   assign act_en[IDX_D]  = act_d_en;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      localparam int LEN = (g == IDX_D) ? D_LEN : B_LEN;
      tsg_slot_decode #(.CNT_W(POS_W), .SLOT_LEN(LEN)) u_dec (
         .cnt_i (cnt),
         .pos_i (act_pos[g]),
         .en_i  (act_en[g]),
         .hit_o (hit[g])
      );
   end

   assign slot_en_n = ~(synced & (|hit));

   tsg_layout_check #(.POS_W(POS_W), .B_LEN(B_LEN), .D_LEN(D_LEN)) u_chk (
      .pos_i (act_pos),
      .en_i  (act_en),
      .err_o (cfg_err)
   );

   tsg_window u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (fsync),
      .raw_en_n_i (slot_en_n),
      .win_o      (win)
   );

   // R5: the active configuration holds between frame starts
   a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_b_en) && $stable(act_d_en) &&
                 $stable(act_pos[IDX_B1]) && $stable(act_pos[IDX_B2]) &&
                 $stable(act_pos[IDX_D])));

   // R1: before any sync no strobe and no window
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !synced |-> (slot_en_n && !win));

endmodule

// File: tb/tb_tdm_slot_strobe.sv
module tb_tdm_slot_strobe;

   localparam int CLK_PERIOD = 10;
   localparam int FRAME      = 32;
   localparam int SKIP       = 63;

   typedef struct packed {
      logic [4:0] b1;
      logic [4:0] b2;
      logic [4:0] d;
      logic       eb;
      logic       ed;
      logic       err;
      logic [5:0] lim;
   } vec_t;

   // lim: last position at which win is still 1 (SKIP = not checked)
   localparam vec_t VECS [12] = '{
      '{5'd0,  5'd8,  5'd16, 1'b1, 1'b1, 1'b0, 6'd18},
      '{5'd2,  5'd10, 5'd0,  1'b1, 1'b1, 1'b0, 6'd18},
      '{5'd10, 5'd0,  5'd8,  1'b1, 1'b1, 1'b0, 6'd18},
      '{5'd0,  5'd8,  5'd20, 1'b1, 1'b0, 1'b0, 6'd16},
      '{5'd8,  5'd0,  5'd3,  1'b1, 1'b0, 1'b0, 6'd16},
      '{5'd4,  5'd12, 5'd0,  1'b0, 1'b1, 1'b0, 6'd2},
      '{5'd0,  5'd8,  5'd5,  1'b0, 1'b1, 1'b1, 6'd63},
      '{5'd0,  5'd10, 5'd8,  1'b1, 1'b1, 1'b0, 6'd18},
      '{5'd0,  5'd9,  5'd17, 1'b1, 1'b1, 1'b1, 6'd63},
      '{5'd0,  5'd4,  5'd12, 1'b1, 1'b1, 1'b1, 6'd63},
      '{5'd0,  5'd8,  5'd16, 1'b0, 1'b0, 1'b0, 6'd32},
      '{5'd0,  5'd16, 5'd8,  1'b1, 1'b0, 1'b1, 6'd63}
   };

   logic       clk;
   logic       rst_n;
   logic       fsync;
   logic [4:0] cfg_b1_pos;
   logic [4:0] cfg_b2_pos;
   logic [4:0] cfg_d_pos;
   logic       cfg_b_en;
   logic       cfg_d_en;
   logic       slot_en_n;
   logic       win;
   logic       cfg_err;

   int total = 0;
   int bad   = 0;
   logic finished = 1'b0;

   tdm_slot_strobe dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync      (fsync),
      .cfg_b1_pos (cfg_b1_pos),
      .cfg_b2_pos (cfg_b2_pos),
      .cfg_d_pos  (cfg_d_pos),
      .cfg_b_en   (cfg_b_en),
      .cfg_d_en   (cfg_d_en),
      .slot_en_n  (slot_en_n),
      .win        (win),
      .cfg_err    (cfg_err)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   function automatic logic in_win(input int c, input int p, input int l);
      return (c >= p) && (c < p + l);
   endfunction

   function automatic logic exp_en_n(input int c, input vec_t v);
      logic on;
      on = (v.eb && (in_win(c, int'(v.b1), 8) || in_win(c, int'(v.b2), 8))) ||
           (v.ed && in_win(c, int'(v.d), 2));
      return !on;
   endfunction

   task automatic apply(input vec_t v);
      cfg_b1_pos = v.b1;
      cfg_b2_pos = v.b2;
      cfg_d_pos  = v.d;
      cfg_b_en   = v.eb;
      cfg_d_en   = v.ed;
   endtask

   task automatic step(input logic fs);
      @(negedge clk);
      fsync = fs;
      @(posedge clk);
      #2;
   endtask

   // wmode: 0 = window from lim, 1 = window must be 0, 2 = window not checked
   task automatic run_frame(input vec_t v, input logic fs, input int c0,
                            input int c1, input int wmode);
      for (int c = c0; c <= c1; c++) begin
         step(fs && (c == c0));
         chk(slot_en_n == exp_en_n(c, v), (v.eb && !v.ed) ? "R4 strobe" : "R3 strobe",
             int'(slot_en_n), int'(exp_en_n(c, v)));
         if (c == 0)
            chk(cfg_err == v.err, "R8 cfg_err", int'(cfg_err), int'(v.err));
         if (wmode == 0 && v.lim != 6'(SKIP))
            chk(win == (c <= int'(v.lim)), (c == 0) ? "R6 win set" : "R7 win",
                int'(win), int'(c <= int'(v.lim)));
         else if (wmode == 1)
            chk(win == 1'b0, "R7 win stays low", int'(win), 0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      fsync = 1'b0;
      apply(VECS[0]);
      repeat (3) @(posedge clk);
      #2;
      chk(slot_en_n == 1'b1 && win == 1'b0 && cfg_err == 1'b0, "R1 in reset",
          int'({slot_en_n, win, cfg_err}), 4);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: no sync yet, configuration present but ignored
      for (int i = 0; i < 5; i++) begin
         step(1'b0);
         chk(slot_en_n == 1'b1, "R1 strobe idle", int'(slot_en_n), 1);
         chk(win == 1'b0, "R1 win idle", int'(win), 0);
         chk(cfg_err == 1'b0, "R1 err idle", int'(cfg_err), 0);
      end

      // Table walk: one synced frame per vector
      for (int k = 0; k < 12; k++) begin
         apply(VECS[k]);
         run_frame(VECS[k], 1'b1, 0, FRAME - 1, 0);
      end

      // R2: wrap without sync repeats the pattern, window stays closed (R7)
      apply(VECS[0]);
      run_frame(VECS[0], 1'b1, 0, FRAME - 1, 0);
      run_frame(VECS[0], 1'b0, 0, FRAME - 1, 1);

      // R5: mid-frame change deferred to the next frame boundary
      run_frame(VECS[0], 1'b1, 0, 3, 0);
      begin
         vec_t vn;
         vn = '{5'd0, 5'd8, 5'd16, 1'b0, 1'b1, 1'b1, 6'd63};
         apply(vn);
         run_frame(VECS[0], 1'b0, 4, FRAME - 1, 0);
         run_frame(vn, 1'b0, 0, FRAME - 1, 1);
      end

      // R2/R6: resync in the middle of a frame restarts position and window
      apply(VECS[0]);
      run_frame(VECS[0], 1'b1, 0, 20, 0);
      run_frame(VECS[0], 1'b1, 0, FRAME - 1, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule